// File: doc/BRIEF.md
# Ultra DMA Burst Host Engine

This block is the host end of a double-edge DMA data burst on a parallel ATA port. A burst opens only when the device is requesting and the host issues a start pulse. The block then pulls its acknowledge low and moves 16-bit words in the chosen direction. For writes to disk it takes words from a ready/valid stream. It places each word on the data bus and toggles its write strobe once, so that every rising and every falling edge carries one word. For reads from disk it oversamples the device strobe and the data bus with the system clock. Every change in the synchronized strobe level stores the data sampled with it into a small receive FIFO, which the host drains through a second ready/valid stream.

Either side may pause the transfer. During writes, the device raises its active-low ready line and the block stops toggling. During reads, the block raises its own active-low ready line once the FIFO fills up to a threshold. It still absorbs the few words that are already in flight. A burst ends when the programmed length is reached or when the device withdraws its request. The block then raises stop for a fixed number of clocks, releases the acknowledge, and compares a running 16-bit CRC with the value reported by the device.

Top module: `udma_host`

## Requirements
- R1: After reset, dmack_no=1, stop_o=0, hstrobe_o=1, hdmardy_no=1, rd_valid_o=0 and done_o=0.
- R2: A start_i pulse is taken only while the synchronized dmarq_i is high. dmack_no is then low at the first falling clock edge after the rising edge that sampled start_i. A start_i pulse with dmarq_i low has no effect.
- R3: In a write burst, every word accepted through wr_valid_i/wr_ready_o appears on dd_o in the same clock as exactly one toggle of hstrobe_o, and words leave in acceptance order. dd_oe_o is high from acknowledge until the end of stop.
- R4: While ddmardy_ni has been high for three clocks, hstrobe_o does not toggle, wr_ready_o stays 0 and no word is accepted, even while wr_valid_i is held high.
- R5: In a read burst, each level change of dstrobe_i, with dd_i changed at the same time, stores one word into the FIFO. Words reach rd_data_o in arrival order.
- R6: During a read burst, hdmardy_no goes high whenever the FIFO holds at least DEPTH-SLACK words. Up to SLACK further words are still accepted with no loss and no overflow.
- R7: Once xfer_len_i words have moved, stop_o is high for exactly STOP_HOLD clocks. dmack_no goes high in the clock after the last of them, and never while stop_o is high.
- R8: If the synchronized dmarq_i falls during a burst, the burst ends through the same stop sequence as R7.
- R9: The CRC starts from 0x4ABA at each burst and takes in every moved word MSB first with polynomial 0x1021. In the clock in which dmack_no is released, done_o pulses for one clock. crc_err_o then shows whether crc_o differs from dev_crc_i and holds that value until the next burst starts.
- R10: hdmardy_no is high whenever dmack_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that opens a burst |
| write_i | input | 1 | 1 = write to disk, 0 = read from disk |
| xfer_len_i | input | LEN_W | Number of words in the burst |
| dev_crc_i | input | 16 | CRC value reported by the device |
| wr_data_i | input | DW | Write stream data |
| wr_valid_i | input | 1 | Write stream valid |
| wr_ready_o | output | 1 | Write stream ready |
| rd_data_o | output | DW | Read stream data (FIFO head) |
| rd_valid_o | output | 1 | Read stream valid |
| rd_ready_i | input | 1 | Read stream ready |
| dmarq_i | input | 1 | Device DMA request |
| dmack_no | output | 1 | DMA acknowledge, active low |
| stop_o | output | 1 | Burst stop |
| hstrobe_o | output | 1 | Host write strobe, idles high |
| hdmardy_no | output | 1 | Host ready for read bursts, active low |
| dstrobe_i | input | 1 | Device read strobe |
| ddmardy_ni | input | 1 | Device ready for write bursts, active low |
| dd_i | input | DW | Data bus from device |
| dd_o | output | DW | Data bus to device |
| dd_oe_o | output | 1 | Data bus output enable |
| done_o | output | 1 | One-clock end-of-burst pulse |
| crc_err_o | output | 1 | CRC mismatch flag |
| crc_o | output | 16 | Running CRC of the current or last burst |

## Verification
The receive FIFO can take a word from the device strobe and hand a word to the host in the same clock. The same holds when it is near the pause threshold, where hdmardy_no is decided on the level that results. The bench provokes this by letting the device stream until the block pauses, then releasing rd_ready_i while the sender is still resuming, so that pushes and pops overlap. It judges the result by the delivered word order, by the absence of any lost or repeated word, and by the FIFO level never passing its depth.

// File: rtl/udma_pkg.sv
`timescale 1ns/1ps
package udma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACK, ST_BURST, ST_STOP, ST_CRC
  } burst_state_e;

  localparam logic [15:0] CRC_SEED = 16'h4ABA;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  // one 16-bit word into the CRC, MSB first
  function automatic logic [15:0] crc_step(logic [15:0] crc, logic [15:0] word);
    logic [15:0] c;
    c = crc;
    for (int i = 15; i >= 0; i--) begin
      if (c[15] ^ word[i]) c = {c[14:0], 1'b0} ^ CRC_POLY;
      else                 c = {c[14:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/udma_sync.sv
`timescale 1ns/1ps
module udma_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) st_q <= '0;
      else         st_q <= d_i;
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) st_q <= '0;
      else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/udma_rx_fifo.sv
`timescale 1ns/1ps
module udma_rx_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,           // power of two
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic [AW:0]   level_o
);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   level_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (level_q != FULL);
  assign do_pop  = pop_i && (level_q != '0);

  always_ff @(posedge clk_i)
    if (do_push) mem_q[wptr_q] <= data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      level_q <= level_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  assign data_o  = mem_q[rptr_q];
  assign valid_o = (level_q != '0);
  assign level_o = level_q;
endmodule

// File: rtl/udma_crc.sv
`timescale 1ns/1ps
module udma_crc (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [15:0] data_i,
  output logic [15:0] crc_o
);
  import udma_pkg::*;
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    crc_q <= CRC_SEED;
    else if (clr_i) crc_q <= CRC_SEED;
    else if (en_i)  crc_q <= crc_step(crc_q, data_i);

  assign crc_o = crc_q;
endmodule

// File: rtl/udma_host.sv
`timescale 1ns/1ps
module udma_host #(
  parameter int DW        = 16,
  parameter int LEN_W     = 16,
  parameter int DEPTH     = 8,
  parameter int SLACK     = 3,
  parameter int STOP_HOLD = 4,
  parameter int SYNC      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [LEN_W-1:0] xfer_len_i,
  input  logic [15:0]      dev_crc_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  input  logic             dmarq_i,
  output logic             dmack_no,
  output logic             stop_o,
  output logic             hstrobe_o,
  output logic             hdmardy_no,
  input  logic             dstrobe_i,
  input  logic             ddmardy_ni,
  input  logic [DW-1:0]    dd_i,
  output logic [DW-1:0]    dd_o,
  output logic             dd_oe_o,
  output logic             done_o,
  output logic             crc_err_o,
  output logic [15:0]      crc_o
);
  import udma_pkg::*;

  localparam int AW       = $clog2(DEPTH);
  localparam int PAUSE_AT = DEPTH - SLACK;
  localparam int HW       = $clog2(STOP_HOLD + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(STOP_HOLD - 1);
  localparam int SW       = DW + 3;

  burst_state_e  state_q, state_d;
  logic          write_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [HW-1:0] hold_q;
  logic          strobe_q, hstrobe_q, crc_err_q;
  logic [DW-1:0] dd_q;

  // device side oversampling: request, strobe, ready and data share one chain
  logic [SW-1:0] raw, syn;
  logic          s_dmarq, s_strobe, s_rdy_n;
  logic [DW-1:0] s_dd;

  assign raw = {dmarq_i, dstrobe_i, ddmardy_ni, dd_i};

  udma_sync #(.W(SW), .STAGES(SYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {s_dmarq, s_strobe, s_rdy_n, s_dd} = syn;

  logic accept, in_burst, cnt_done, fire_wr, push_rd, hold_done;
  logic [AW:0] fifo_level;

  assign accept    = (state_q == ST_IDLE) && start_i && s_dmarq;
  assign in_burst  = (state_q == ST_BURST);
  assign cnt_done  = (cnt_q == len_q);
  assign fire_wr   = in_burst && write_q && !s_rdy_n && !cnt_done && wr_valid_i;
  assign push_rd   = in_burst && !write_q && !cnt_done && (s_strobe != strobe_q);
  assign hold_done = (state_q == ST_STOP) && (hold_q == HOLD_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_ACK;
      ST_ACK:   state_d = ST_BURST;
      ST_BURST: if (cnt_done || !s_dmarq) state_d = ST_STOP;
      ST_STOP:  if (hold_done) state_d = ST_CRC;
      ST_CRC:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      write_q   <= 1'b0;
      len_q     <= '0;
      cnt_q     <= '0;
      hold_q    <= '0;
      strobe_q  <= 1'b0;
      hstrobe_q <= 1'b1;
      dd_q      <= '0;
      crc_err_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe_q <= s_strobe;
      if (accept) begin
        write_q   <= write_i;
        len_q     <= xfer_len_i;
        cnt_q     <= '0;
        crc_err_q <= 1'b0;
      end
      if (fire_wr || push_rd) cnt_q <= cnt_q + 1'b1;
      if (fire_wr) begin
        dd_q      <= wr_data_i;
        hstrobe_q <= ~hstrobe_q;
      end
      hold_q <= (state_q == ST_STOP) ? hold_q + 1'b1 : '0;
      if (hold_done) crc_err_q <= (crc_o != dev_crc_i);
    end
  end

  udma_crc u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .en_i  (fire_wr || push_rd),
    .data_i(write_q ? wr_data_i : s_dd),
    .crc_o (crc_o)
  );

  udma_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push_rd),
    .data_i (s_dd),
    .pop_i  (rd_ready_i),
    .data_o (rd_data_o),
    .valid_o(rd_valid_o),
    .level_o(fifo_level)
  );

  assign wr_ready_o = in_burst && write_q && !s_rdy_n && !cnt_done;
  assign dmack_no   = !(state_q inside {ST_ACK, ST_BURST, ST_STOP});
  assign stop_o     = (state_q == ST_STOP);
  assign hstrobe_o  = hstrobe_q;
  assign hdmardy_no = !(in_burst && !write_q && !cnt_done && (int'(fifo_level) < PAUSE_AT));
  assign dd_o       = dd_q;
  assign dd_oe_o    = write_q && !dmack_no;
  assign done_o     = (state_q == ST_CRC);
  assign crc_err_o  = crc_err_q;
endmodule

// File: rtl/udma_host_chk.sv
`timescale 1ns/1ps
module udma_host_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dmack_no,
  input logic             stop_o,
  input logic             hstrobe_o,
  input logic             ddmardy_ni,
  input logic             hdmardy_no,
  input logic             done_o,
  input logic [LVL_W-1:0] fifo_level
);
  a_r4_strobe_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ddmardy_ni && $past(ddmardy_ni) && $past(ddmardy_ni, 2) && $past(ddmardy_ni, 3))
      |-> $stable(hstrobe_o));

  a_r3_strobe_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hstrobe_o) |-> !dmack_no);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level <= LVL_W'(DEPTH));

  a_r7_release_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dmack_no) |-> $past(stop_o));

  a_r7_stop_holds_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !dmack_no);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmack_no |-> hdmardy_no);
endmodule

bind udma_host udma_host_chk #(.DEPTH(DEPTH), .LVL_W($clog2(DEPTH) + 1)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dmack_no  (dmack_no),
  .stop_o    (stop_o),
  .hstrobe_o (hstrobe_o),
  .ddmardy_ni(ddmardy_ni),
  .hdmardy_no(hdmardy_no),
  .done_o    (done_o),
  .fifo_level(fifo_level)
);

// File: tb/udma_host_tb_top.sv
`timescale 1ns/1ps
module udma_host_tb_top;
  localparam int DW = 16, LEN_W = 8, DEPTH = 8, SLACK = 3, STOP_HOLD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, write = 0, wr_valid = 0, rd_ready = 0;
  logic dmarq = 0, dstrobe = 0, ddmardy_n = 0;
  logic [LEN_W-1:0] len = '0;
  logic [15:0] dev_crc = '0, crc;
  logic [DW-1:0] wr_data = '0, dd_in = '0, rd_data, dd_out;
  logic wr_ready, rd_valid, dmack_n, stop, hstrobe, hdmardy_n, dd_oe, done, crc_err;

  always #10 clk = ~clk;

  udma_host #(.DW(DW), .LEN_W(LEN_W), .DEPTH(DEPTH), .SLACK(SLACK), .STOP_HOLD(STOP_HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(write), .xfer_len_i(len),
    .dev_crc_i(dev_crc), .wr_data_i(wr_data), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .dmarq_i(dmarq),
    .dmack_no(dmack_n), .stop_o(stop), .hstrobe_o(hstrobe), .hdmardy_no(hdmardy_n),
    .dstrobe_i(dstrobe), .ddmardy_ni(ddmardy_n), .dd_i(dd_in), .dd_o(dd_out), .dd_oe_o(dd_oe),
    .done_o(done), .crc_err_o(crc_err), .crc_o(crc)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] wdat [64];
  logic [15:0] wq [64];
  logic [15:0] rq [64];
  int wn = 0, rn = 0;
  logic hs_last = 1'b1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h4ABA;
    for (int k = 0; k < n; k++)
      for (int b = 15; b >= 0; b--) begin
        logic fb = c[15] ^ wdat[k][b];
        c = c << 1;
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  // device-side and host-side observers
  always @(negedge clk) if (rst_n) begin
    if (hstrobe !== hs_last) begin
      if (wn < 64) wq[wn] = dd_out;
      wn++;
      hs_last = hstrobe;
    end
    if (rd_valid && rd_ready) begin
      if (rn < 64) rq[rn] = rd_data;
      rn++;
    end
  end

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) wdat[i] = 16'((seed * 16'h3B1) ^ (i * 16'h1357) ^ (i << 9));
  endtask

  task automatic open_burst(input bit w, input int n, input bit bad_crc);
    wn = 0; rn = 0;
    dev_crc = ref_crc(n) ^ {15'd0, bad_crc};
    dmarq = 1;
    repeat (4) @(negedge clk);
    write = w; len = LEN_W'(n); start = 1;
    @(negedge clk);
    start = 0;
    check(dmack_n == 1'b0, "R2", "ack after start", dmack_n, 0);
    check(dd_oe == w, "R3", "data enable", dd_oe, w);
  endtask

  task automatic close_burst(input string req, input bit exp_err, input int n);
    int sc = 0, t = 0;
    while (!stop && t < 400) begin @(negedge clk); t++; end
    while (stop && sc < 50) begin @(negedge clk); sc++; end
    check(sc == STOP_HOLD, req, "stop hold clocks", sc, STOP_HOLD);
    check(dmack_n == 1'b1 && done == 1'b1, "R9", "release with done", {dmack_n, done}, 3);
    check(crc == ref_crc(n), "R9", "crc value", crc, ref_crc(n));
    @(negedge clk);
    check(done == 1'b0 && crc_err == exp_err, "R9", "done pulse and crc flag", {done, crc_err}, exp_err);
    dmarq = 0;
  endtask

  task automatic send_words(input int n, input int pause_at);
    for (int i = 0; i < n; i++) begin
      if (i == pause_at) begin
        int w0;
        logic hs;
        bit ok = 1;
        ddmardy_n = 1;
        repeat (4) @(negedge clk);
        hs = hstrobe; w0 = wn;
        wr_data = wdat[i]; wr_valid = 1;
        repeat (8) begin @(negedge clk); if (hstrobe !== hs || wr_ready) ok = 0; end
        check(ok, "R4", "strobe frozen while device paused", ok, 1);
        check(wn == w0, "R4", "no word taken while paused", wn, w0);
        ddmardy_n = 0;
      end
      wr_data = wdat[i]; wr_valid = 1;
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_valid = 0;
    end
  endtask

  task automatic dev_send(input int n);
    for (int i = 0; i < n; i++) begin
      while (hdmardy_n) @(negedge clk);
      dd_in = wdat[i]; dstrobe = ~dstrobe;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic cmp_words(input string req, input bit rd, input int n);
    int bad = 0;
    int got = rd ? rn : wn;
    check(got == n, req, "word count", got, n);
    for (int i = 0; i < n && i < 64; i++)
      if ((rd ? rq[i] : wq[i]) !== wdat[i]) bad++;
    check(bad == 0, req, "words in order", bad, 0);
  endtask

  task automatic t_reset;
    check(dmack_n && !stop && hstrobe && hdmardy_n && !rd_valid && !done, "R1", "reset state",
          {dmack_n, stop, hstrobe, hdmardy_n, rd_valid, done}, 6'b101100);
  endtask

  task automatic t_no_request;
    dmarq = 0; write = 1; len = 4;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    check(dmack_n == 1'b1, "R2", "no ack without request", dmack_n, 1);
  endtask

  task automatic t_write(input int n, input int pause_at, input bit bad, input int seed);
    fill(n, seed);
    open_burst(1, n, bad);
    fork
      send_words(n, pause_at);
      close_burst("R7", bad, n);
    join
    cmp_words("R3", 0, n);
    check(hdmardy_n == 1'b1, "R10", "host ready idle", hdmardy_n, 1);
  endtask

  task automatic t_read;
    int n = 12;
    fill(n, 7);
    rd_ready = 0;
    open_burst(0, n, 0);
    fork
      dev_send(n);
      begin
        repeat (30) @(negedge clk);
        check(hdmardy_n == 1'b1, "R6", "pause at threshold", hdmardy_n, 1);
        rd_ready = 1;
      end
      close_burst("R7", 0, n);
    join
    repeat (20) @(negedge clk);
    cmp_words("R5", 1, n);
    check(rn == n, "R6", "no words lost across pause", rn, n);
    check(hdmardy_n == 1'b1, "R10", "host ready idle", hdmardy_n, 1);
  endtask

  task automatic t_dev_end;
    int n = 5;
    fill(n, 11);
    rd_ready = 1;
    open_burst(0, 20, 0);
    dev_crc = ref_crc(n);
    fork
      begin dev_send(n); repeat (6) @(negedge clk); dmarq = 0; end
      close_burst("R8", 0, n);
    join
    repeat (4) @(negedge clk);
    cmp_words("R8", 1, n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_no_request();
    t_write(6, -1, 0, 1);
    t_write(8, 3, 0, 2);
    t_write(4, -1, 1, 3);
    t_write(5, -1, 0, 4);
    t_read();
    t_dev_end();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule